// File: doc/BRIEF.md
# Programmable AND-Plane Logic Array with Output Feedback

This block is a small sum-of-products logic array. Four external input bits drive four output sections. Each section has three product terms, and each product term is an AND gate with programmable links to the true and complement form of every variable it can see. The three product terms of a section go into an OR gate that cannot be programmed. The output of the first section is also sent back into the product terms of the other three sections as an extra variable, in both polarities. A function that needs more than three product terms can therefore be split: part of it is built in the first section, and a later section ORs in the rest.

The link pattern is held in a configuration register. A parallel write port loads one section's word per clock cycle. Until every section has been written at least once after reset, a valid flag stays low and every output is held at 0. The outputs are combinational in the inputs and in the stored links.

Top module: `pal_array`

## Requirements
- R1: After reset `cfg_valid` is 0 and `out_pins` is 0.
- R2: `cfg_valid` goes to 1 at the clock edge that stores the last of the four sections not yet written since reset. It then stays at 1 until the next reset, including across rewrites.
- R3: While `cfg_valid` is 0, `out_pins` is 0 for every value of `in_pins`.
- R4: In section word s, product term t uses `cfg_data` bits [t*10+9 : t*10]. For variable v, link bit 2v selects the true literal and link bit 2v+1 selects the complement literal. Variables 0 to 3 are `in_pins[0..3]` and variable 4 is the feedback. The term is the AND of the literals that are linked.
- R5: A product term with no links enabled evaluates to 0. A term that links both polarities of the same variable also evaluates to 0.
- R6: While `cfg_valid` is 1, `out_pins[s]` is the OR of the three product terms of section s.
- R7: Variable 4 in sections 1 to 3 equals `out_pins[0]`, so a later section can combine the first section's function with its own terms.
- R8: The variable-4 link bits in section 0's word have no effect on section 0's output.
- R9: A write to section s after `cfg_valid` is 1 changes only section s, and the change is visible from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Write strobe for one section's link word |
| cfg_sel | input | 2 | Section being written |
| cfg_data | input | 30 | Link bits for the three product terms of the selected section |
| cfg_valid | output | 1 | High once every section has been written since reset |
| in_pins | input | 4 | Logic inputs |
| out_pins | output | 4 | Section outputs, forced to 0 while not valid |

## Verification
All sixteen input values are applied to each programmed pattern, and each output bit is compared with a Boolean formula evaluated in the bench. The first pattern contains two-literal products, a term that links both polarities of one variable, and a wide four-literal product. This pattern separates correct literal polarity from swapped link bits. It also gives one section that ORs the feedback with its own term and another section that uses the complement of the feedback, so a broken feedback path or a dropped inversion shows up. A link placed on the feedback variable inside section 0 must leave that output unchanged. After one section is rewritten, a second full sweep checks that only that output changes. Before the fourth section is written, the sweeps check that the outputs stay at 0 and the valid flag stays low.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Polarity offset of a literal within a variable's link pair
  localparam int LIT_TRUE = 0;
  localparam int LIT_COMP = 1;
  localparam int LITS_PER_VAR = 2;
endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store #(
  parameter int N_SEC = 4,
  parameter int WW    = 30,
  localparam int SW   = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SW-1:0]        cfg_sel,
  input  logic [WW-1:0]        cfg_data,
  output logic [N_SEC*WW-1:0]  cfg_words,
  output logic                 cfg_valid,
  output logic                 rst_sync_n
);
  logic rst_meta_q, rst_sync_q;
  logic [WW-1:0]    words_q [N_SEC];
  logic [WW-1:0]    words_d [N_SEC];
  logic [N_SEC-1:0] written_q, written_d;
  logic             valid_q, valid_d;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_sync_n = rst_sync_q;

  always_comb begin
    written_d = written_q;
    for (int s = 0; s < N_SEC; s++) begin
      words_d[s] = words_q[s];
      if (cfg_we && (int'(cfg_sel) == s)) begin
        words_d[s]   = cfg_data;
        written_d[s] = 1'b1;
      end
    end
    valid_d = &written_d;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      written_q <= '0;
      valid_q   <= 1'b0;
      for (int s = 0; s < N_SEC; s++) words_q[s] <= '0;
    end else if (cfg_we) begin
      written_q <= written_d;
      valid_q   <= valid_d;
      for (int s = 0; s < N_SEC; s++) words_q[s] <= words_d[s];
    end
  end

  for (genvar s = 0; s < N_SEC; s++) begin : g_flat
    assign cfg_words[s*WW +: WW] = words_q[s];
  end
  assign cfg_valid = valid_q;

  p_valid_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    valid_q |=> valid_q);
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(valid_q) |-> $past(cfg_we));
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cfg_we |=> (words_q[$past(cfg_sel)] == $past(cfg_data)));
endmodule

// File: rtl/pal_and_term.sv
module pal_and_term #(
  parameter int LW = 10
) (
  input  logic [LW-1:0] lits,
  input  logic [LW-1:0] links,
  output logic          prod
);
  // Unlinked literals are treated as 1; an empty gate is forced to 0
  assign prod = (|links) & (&(lits | ~links));
endmodule

// File: rtl/pal_section.sv
module pal_section #(
  parameter int N_TERM = 3,
  parameter int LW     = 10,
  localparam int WW    = N_TERM * LW
) (
  input  logic [LW-1:0]     lits,
  input  logic [WW-1:0]     links,
  output logic [N_TERM-1:0] terms,
  output logic              sum
);
  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pal_and_term #(.LW(LW)) u_term (
      .lits  (lits),
      .links (links[t*LW +: LW]),
      .prod  (terms[t])
    );
  end
  // Fixed OR plane
  assign sum = |terms;
endmodule

// File: rtl/pal_array.sv
module pal_array #(
  parameter int N_IN   = 4,
  parameter int N_SEC  = 4,
  parameter int N_TERM = 3,
  localparam int N_VAR = N_IN + 1,
  localparam int LW    = pal_pkg::LITS_PER_VAR * N_VAR,
  localparam int WW    = N_TERM * LW,
  localparam int SW    = (N_SEC > 1) ? $clog2(N_SEC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_sel,
  input  logic [WW-1:0]     cfg_data,
  output logic              cfg_valid,
  input  logic [N_IN-1:0]   in_pins,
  output logic [N_SEC-1:0]  out_pins
);
  import pal_pkg::*;

  logic [N_SEC*WW-1:0] cfg_words;
  logic                rst_sync_n;
  logic [N_SEC-1:0]    sec_sum;
  logic [N_TERM-1:0]   sec_terms [N_SEC];
  logic [LW-1:0]       lits;
  logic                fb;

  pal_cfg_store #(.N_SEC(N_SEC), .WW(WW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_data   (cfg_data),
    .cfg_words  (cfg_words),
    .cfg_valid  (cfg_valid),
    .rst_sync_n (rst_sync_n)
  );

  // Literal buffer: true/complement pair per input, feedback pair on top
  assign fb = sec_sum[0];
  always_comb begin
    for (int v = 0; v < N_IN; v++) begin
      lits[LITS_PER_VAR*v + LIT_TRUE] = in_pins[v];
      lits[LITS_PER_VAR*v + LIT_COMP] = ~in_pins[v];
    end
    lits[LITS_PER_VAR*N_IN + LIT_TRUE] = fb;
    lits[LITS_PER_VAR*N_IN + LIT_COMP] = ~fb;
  end

  // Section 0 never sees its own feedback: its links to it are cut
  localparam logic [LW-1:0] NO_FB_LW = {{LITS_PER_VAR{1'b0}}, {(LW-LITS_PER_VAR){1'b1}}};
  localparam logic [WW-1:0] NO_FB    = {N_TERM{NO_FB_LW}};

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    logic [WW-1:0] sec_links;
    if (s == 0) begin : g_root
      assign sec_links = cfg_words[s*WW +: WW] & NO_FB;
    end else begin : g_fed
      assign sec_links = cfg_words[s*WW +: WW];
    end
    pal_section #(.N_TERM(N_TERM), .LW(LW)) u_sec (
      .lits  (lits),
      .links (sec_links),
      .terms (sec_terms[s]),
      .sum   (sec_sum[s])
    );

    p_or_of_terms_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      cfg_valid |-> (out_pins[s] == |sec_terms[s]));
  end

  assign out_pins = cfg_valid ? sec_sum : '0;

  p_dark_until_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> (out_pins == '0));
endmodule

// File: tb/pal_array_test.sv
module pal_array_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [29:0] cfg_data;
  logic        cfg_valid;
  logic [3:0]  in_pins;
  logic [3:0]  out_pins;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pal_array uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .cfg_valid(cfg_valid), .in_pins(in_pins),
    .out_pins(out_pins)
  );

  function automatic logic [9:0] lk(input int v, input int comp);
    return 10'(1) << (2*v + comp);
  endfunction

  function automatic logic [29:0] word(input logic [9:0] t0, input logic [9:0] t1,
                                       input logic [9:0] t2);
    return {t2, t1, t0};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [29:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0; in_pins = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Expected functions from the requirements
  function automatic logic f0(input logic [3:0] x);
    return (x[0] & x[1]) | (x[2] & ~x[3]);
  endfunction

  function automatic logic [3:0] exp_a(input logic [3:0] x);
    logic [3:0] e;
    e[0] = f0(x);
    e[1] = f0(x) | (x[3] & ~x[0]);
    e[2] = ~f0(x) & x[1];
    e[3] = ~x[1] | (&x);
    return e;
  endfunction

  task automatic sweep_dark(input string tag);
    for (int i = 0; i < 16; i++) begin
      in_pins = 4'(i);
      #2;
      chk(tag, out_pins, 4'b0000);
    end
  endtask

  initial begin
    logic [3:0] e;
    do_reset();
    // R1 reset state
    chk("R1 valid", {3'b0, cfg_valid}, 4'b0000);
    chk("R1 out", out_pins, 4'b0000);

    // Config A; section 0 term 2 links only the feedback (R8, R5)
    wr(0, word(lk(0,0)|lk(1,0), lk(2,0)|lk(3,1), lk(4,0)));
    wr(1, word(lk(4,0), lk(3,0)|lk(0,1), 10'd0));
    wr(3, word(lk(1,1), lk(0,0)|lk(1,0)|lk(2,0)|lk(3,0), 10'd0));
    chk("R2 not yet valid", {3'b0, cfg_valid}, 4'b0000);
    sweep_dark("R3 dark before valid");
    wr(2, word(lk(4,1)|lk(1,0), lk(0,0)|lk(0,1), 10'd0));
    chk("R2 valid after last section", {3'b0, cfg_valid}, 4'b0001);

    // R4 R5 R6 R7 R8 exhaustive sweep
    for (int i = 0; i < 16; i++) begin
      in_pins = 4'(i);
      #2;
      e = exp_a(4'(i));
      chk($sformatf("R8 R4 sec0 in=%0d", i), {3'b0, out_pins[0]}, {3'b0, e[0]});
      chk($sformatf("R7 R6 sec1 in=%0d", i), {3'b0, out_pins[1]}, {3'b0, e[1]});
      chk($sformatf("R7 R5 sec2 in=%0d", i), {3'b0, out_pins[2]}, {3'b0, e[2]});
      chk($sformatf("R4 sec3 in=%0d", i), {3'b0, out_pins[3]}, {3'b0, e[3]});
    end

    // R9 rewrite section 2 only
    wr(2, word(lk(0,0), lk(3,0), 10'd0));
    chk("R2 stays valid", {3'b0, cfg_valid}, 4'b0001);
    for (int i = 0; i < 16; i++) begin
      in_pins = 4'(i);
      #2;
      e = exp_a(4'(i));
      e[2] = in_pins[0] | in_pins[3];
      chk($sformatf("R9 rewrite in=%0d", i), out_pins, e);
    end

    // R1 again after a second reset
    do_reset();
    chk("R1 valid after reset", {3'b0, cfg_valid}, 4'b0000);
    sweep_dark("R3 dark after reset");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule